// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block keeps the per-interrupt state of 64 interrupt sources behind a 32-bit register port. Each source has an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit CPU target mask and a trigger mode, either level or edge. Incoming source lines are latched into the pending bits according to each source's mode. Software changes the state through paired write-one-to-set and write-one-to-clear words. Priority and target fields are packed four to a word, one per byte lane, and can be written one lane at a time with byte enables.

Every cycle an arbiter looks at the sources that are enabled, pending, not active and aimed at processor 0. It offers the most urgent of them, with its ID and priority, to a CPU interface. The CPU interface acknowledges an ID, which makes it active, and later signals end of interrupt, which releases it. IDs 0 to 15 are the software-raised range, 16 to 31 the per-processor peripheral range and 32 to 63 the shared peripheral range. All of them are treated alike here.

Top module: `irq_dist`

## Requirements
- R1: After reset every enable, pending, active, priority, target and trigger bit is 0, the distributor is off and `cpu_irq` is low.
- R2: Bit 0 of the word at byte offset 0x000 switches the distributor on. While it is 0, `cpu_irq` stays low.
- R3: Enable bits are 32 IDs per word. A write to 0x100+4n sets, and a write to 0x180+4n clears, every bit of IDs 32n..32n+31 written as 1. Bits written as 0 change nothing. A read of either offset returns the enable bits.
- R4: Pending bits follow the same scheme: set at 0x200+4n, clear at 0x280+4n, and a read of either returns the pending bits.
- R5: Active bits follow the same scheme: set at 0x300+4n, clear at 0x380+4n, and a read of either returns the active bits.
- R6: The priority of ID i sits at 0x400+4*(i/4), bits [8*(i%4)+7 : 8*(i%4)]. A lower value is more urgent. A write changes only the byte lanes whose byte enable is set.
- R7: The target mask of ID i sits at 0x800+4*(i/4), in the same byte lane as its priority. Only IDs whose mask bit 0 is 1 are offered to the CPU.
- R8: The trigger field of ID i is bits [2*(i%16)+1 : 2*(i%16)] at 0xC00+4*(i/16). Value 0b10 selects edge and 0b00 selects level. The low bit of each field reads back as 0.
- R9: For a level source, its pending bit is set in every cycle its line is high. A low line does not clear it, and neither does an acknowledge.
- R10: For an edge source, a rising edge on its line sets its pending bit. An acknowledge or a clear-pending write clears it. A rising edge in the same cycle as an acknowledge of that ID leaves it pending.
- R11: One cycle after the state changes, `cpu_irq`, `cpu_id` and `cpu_prio` show the eligible ID with the lowest priority value. On a tie the lowest ID wins.
- R12: An acknowledge sets the active bit of `ack_id`. An end of interrupt clears the active bit of `eoi_id`.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte offset bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Registered read data |
| src_line | input | 64 | Interrupt source lines |
| cpu_irq | output | 1 | An eligible interrupt is offered |
| cpu_id | output | 6 | ID of the offered interrupt |
| cpu_prio | output | 8 | Priority of the offered interrupt |
| cpu_ack | input | 1 | Acknowledge strobe |
| ack_id | input | 6 | ID being acknowledged |
| cpu_eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 6 | ID being retired |

## Verification
The pending bit of an edge source can be set by a fresh rising edge and cleared by an acknowledge in the same cycle. The bench raises that line on exactly the cycle it acknowledges the ID and expects the bit to stay set with the active bit also set. A second case holds a level line high during a clear-pending write and expects the bit to survive. Random rounds load enables, pending, active, priorities with many ties, and targets. After each round, and after acknowledging the winner, a bench function predicts the offered ID and priority.

// File: rtl/irq_dist.sv
module irq_dist #(
  parameter int NUM_IRQ = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [11:2]                bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [3:0]                 bus_be,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_IRQ-1:0]         src_line,
  output logic                       cpu_irq,
  output logic [$clog2(NUM_IRQ)-1:0] cpu_id,
  output logic [7:0]                 cpu_prio,
  input  logic                       cpu_ack,
  input  logic [$clog2(NUM_IRQ)-1:0] ack_id,
  input  logic                       cpu_eoi,
  input  logic [$clog2(NUM_IRQ)-1:0] eoi_id
);
  localparam int IDW   = $clog2(NUM_IRQ);
  localparam int WORDS = NUM_IRQ / 32;

  logic                    ctrl_en;
  logic [NUM_IRQ-1:0]      en, pend, act, edge_cfg, src_q;
  logic [NUM_IRQ-1:0][7:0] prio, tgt;

  logic [NUM_IRQ-1:0] en_s, en_c, pd_s, pd_c, ac_s, ac_c;
  logic [NUM_IRQ-1:0] ack_vec, eoi_vec, rise, elig;
  logic [31:0]        wd, rd_mux;
  logic               best_ok;
  logic [IDW-1:0]     best_id;
  logic [7:0]         best_p;

  wire [4:0] blk  = bus_addr[11:7];
  wire [4:0] widx = bus_addr[6:2];
  wire [1:0] grp  = bus_addr[11:10];
  wire [7:0] fidx = bus_addr[9:2];

  assign wd = bus_wdata & {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign ack_vec = cpu_ack ? (NUM_IRQ'(1) << ack_id) : '0;
  assign eoi_vec = cpu_eoi ? (NUM_IRQ'(1) << eoi_id) : '0;
  assign rise = src_line & ~src_q;

  always_comb begin
    en_s = '0; en_c = '0; pd_s = '0; pd_c = '0; ac_s = '0; ac_c = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (bus_wr && widx == 5'(w)) begin
        case (blk)
          5'd2: en_s[w*32 +: 32] = wd;
          5'd3: en_c[w*32 +: 32] = wd;
          5'd4: pd_s[w*32 +: 32] = wd;
          5'd5: pd_c[w*32 +: 32] = wd;
          5'd6: ac_s[w*32 +: 32] = wd;
          5'd7: ac_c[w*32 +: 32] = wd;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      en       <= '0;
      pend     <= '0;
      act      <= '0;
      edge_cfg <= '0;
      src_q    <= '0;
      prio     <= '0;
      tgt      <= '0;
    end else begin
      if (bus_wr && bus_addr == 10'h0 && bus_be[0]) ctrl_en <= bus_wdata[0];
      en    <= (en & ~en_c) | en_s;
      pend  <= (pend & ~pd_c & ~(ack_vec & edge_cfg)) | pd_s
             | (src_line & ~edge_cfg) | (rise & edge_cfg);
      act   <= (act & ~ac_c & ~eoi_vec) | ac_s | ack_vec;
      src_q <= src_line;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (bus_wr && grp == 2'b01 && fidx == 8'(i / 4) && bus_be[i % 4])
          prio[i] <= bus_wdata[(i % 4) * 8 +: 8];
        if (bus_wr && grp == 2'b10 && fidx == 8'(i / 4) && bus_be[i % 4])
          tgt[i] <= bus_wdata[(i % 4) * 8 +: 8];
        if (bus_wr && grp == 2'b11 && fidx == 8'(i / 16) && bus_be[(i % 16) / 4])
          edge_cfg[i] <= bus_wdata[(i % 16) * 2 + 1];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      elig[i] = en[i] & pend[i] & ~act[i] & tgt[i][0] & ctrl_en;
  end

  always_comb begin
    best_ok = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig[i] && (!best_ok || prio[i] <= best_p)) begin
        best_ok = 1'b1;
        best_id = IDW'(i);
        best_p  = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq  <= 1'b0;
      cpu_id   <= '0;
      cpu_prio <= '0;
    end else begin
      cpu_irq  <= best_ok;
      cpu_id   <= best_id;
      cpu_prio <= best_ok ? best_p : 8'h0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == 10'h0) rd_mux = {31'b0, ctrl_en};
    for (int w = 0; w < WORDS; w++) begin
      if (widx == 5'(w)) begin
        case (blk)
          5'd2, 5'd3: rd_mux = en[w*32 +: 32];
          5'd4, 5'd5: rd_mux = pend[w*32 +: 32];
          5'd6, 5'd7: rd_mux = act[w*32 +: 32];
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grp == 2'b01 && fidx == 8'(i / 4)) rd_mux[(i % 4) * 8 +: 8] = prio[i];
      if (grp == 2'b10 && fidx == 8'(i / 4)) rd_mux[(i % 4) * 8 +: 8] = tgt[i];
      if (grp == 2'b11 && fidx == 8'(i / 16)) rd_mux[(i % 16) * 2 +: 2] = {edge_cfg[i], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2
  dist_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !cpu_irq);

  // R12
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> act[$past(ack_id)]);

  // R12
  eoi_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !cpu_ack && !bus_wr) |=> !act[$past(eoi_id)]);

  // R9
  level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_line & ~edge_cfg)) |=>
      ((pend & $past(src_line & ~edge_cfg)) == $past(src_line & ~edge_cfg)));

  // R10
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_line & ~src_q & edge_cfg)) |=>
      ((pend & $past(src_line & ~src_q & edge_cfg)) == $past(src_line & ~src_q & edge_cfg)));
endmodule

// File: tb/irq_dist_test.sv
`timescale 1ns/1ps
module irq_dist_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:2] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic [63:0] src_line;
  logic        cpu_irq;
  logic [5:0]  cpu_id;
  logic [7:0]  cpu_prio;
  logic        cpu_ack, cpu_eoi;
  logic [5:0]  ack_id, eoi_id;

  int checks = 0;
  int fails  = 0;

  bit [63:0] m_en, m_pd, m_ac, m_tg;
  int        m_pr [64];

  always #4 clk = ~clk;

  irq_dist #(.NUM_IRQ(64)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .src_line(src_line),
    .cpu_irq(cpu_irq), .cpu_id(cpu_id), .cpu_prio(cpu_prio),
    .cpu_ack(cpu_ack), .ack_id(ack_id), .cpu_eoi(cpu_eoi), .eoi_id(eoi_id)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[11:2];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(input int id);
    @(negedge clk);
    cpu_ack = 1'b1; ack_id = 6'(id);
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic eoi(input int id);
    @(negedge clk);
    cpu_eoi = 1'b1; eoi_id = 6'(id);
    @(negedge clk);
    cpu_eoi = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic void pick(output bit v, output int id, output int p);
    v = 0; id = 0; p = 255;
    for (int i = 0; i < 64; i++)
      if (m_en[i] && m_pd[i] && !m_ac[i] && m_tg[i] && (!v || m_pr[i] < p)) begin
        v = 1; id = i; p = m_pr[i];
      end
  endfunction

  task automatic check_pick(input string tag);
    bit ev; int eid, ep;
    pick(ev, eid, ep);
    chk({tag, " R11 irq"}, 32'(cpu_irq), 32'(ev));
    if (ev) begin
      chk({tag, " R11 id"}, 32'(cpu_id), 32'(eid));
      chk({tag, " R11 prio"}, 32'(cpu_prio), 32'(ep));
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    src_line = '0; cpu_ack = 0; cpu_eoi = 0; ack_id = '0; eoi_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 0);
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h104, d); chk("R1 enable", d, 0);
    rd(12'h400, d); chk("R1 prio", d, 0);

    // R3 set/clear enable, zero bits ignored
    wr(12'h100, 32'h0000_00F0);
    wr(12'h100, 32'h0000_000F);
    rd(12'h100, d); chk("R3 set", d, 32'h0000_00FF);
    wr(12'h180, 32'h0000_0003);
    rd(12'h100, d); chk("R3 clear", d, 32'h0000_00FC);
    rd(12'h180, d); chk("R13 read via clear offset", d, 32'h0000_00FC);
    wr(12'h180, 32'hFFFF_FFFF);

    // R4 / R5 set/clear words
    wr(12'h204, 32'h8000_0001);
    rd(12'h284, d); chk("R4 pend set", d, 32'h8000_0001);
    wr(12'h284, 32'h0000_0001);
    rd(12'h204, d); chk("R4 pend clear", d, 32'h8000_0000);
    wr(12'h284, 32'hFFFF_FFFF);
    wr(12'h300, 32'h0000_0100);
    rd(12'h380, d); chk("R5 act set", d, 32'h0000_0100);
    wr(12'h380, 32'h0000_0100);
    rd(12'h300, d); chk("R5 act clear", d, 0);

    // R6 byte lane write
    wr(12'h404, 32'hAABB_CCDD, 4'b0100);
    rd(12'h404, d); chk("R6 lane", d, 32'h00BB_0000);
    wr(12'h404, 32'h0, 4'hF);

    // R8 config readback
    wr(12'hC00, 32'hFFFF_FFFF);
    rd(12'hC00, d); chk("R8 cfg", d, 32'hAAAA_AAAA);
    wr(12'hC00, 32'h0);
    rd(12'hFFC, d); chk("R13 unmapped", d, 0);

    // targets to processor 0
    for (int w = 0; w < 16; w++) wr(12'h800 + 12'(w * 4), 32'h0101_0101);

    // R2 distributor off
    wr(12'h100, 32'h0000_0020);
    wr(12'h200, 32'h0000_0020);
    settle();
    chk("R2 off", 32'(cpu_irq), 0);
    wr(12'h000, 32'h1);
    settle();
    chk("R2 on irq", 32'(cpu_irq), 1);
    chk("R11 id5", 32'(cpu_id), 5);

    // R7 target bit 0 gates forwarding
    wr(12'h804, 32'h0000_0000, 4'b0010);
    settle();
    chk("R7 untargeted", 32'(cpu_irq), 0);
    wr(12'h804, 32'h0000_0100, 4'b0010);
    settle();
    chk("R7 retargeted", 32'(cpu_id), 5);

    // R11 tie then priority
    wr(12'h100, 32'h0000_0040);
    wr(12'h200, 32'h0000_0040);
    settle();
    chk("R11 tie lowest id", 32'(cpu_id), 5);
    wr(12'h404, 32'h0000_1000, 4'b0010);
    settle();
    chk("R6 R11 lower value wins", 32'(cpu_id), 6);
    chk("R11 prio", 32'(cpu_prio), 0);

    // R12 ack / eoi
    ack(6);
    settle();
    rd(12'h300, d); chk("R12 active", d, 32'h0000_0040);
    chk("R12 next pick", 32'(cpu_id), 5);
    chk("R12 prio5", 32'(cpu_prio), 32'h10);
    eoi(6);
    rd(12'h300, d); chk("R12 eoi", d, 0);
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h280, 32'hFFFF_FFFF);

    // R9 level source 33
    wr(12'h104, 32'h0000_0006);
    @(negedge clk); src_line[33] = 1'b1;
    @(negedge clk); src_line[33] = 1'b0;
    rd(12'h204, d); chk("R9 level latched", d & 32'h2, 32'h2);
    ack(33);
    rd(12'h204, d); chk("R9 ack keeps level", d & 32'h2, 32'h2);
    wr(12'h284, 32'h2);
    rd(12'h204, d); chk("R9 cleared", d & 32'h2, 0);
    @(negedge clk); src_line[33] = 1'b1;
    wr(12'h284, 32'h2);
    rd(12'h204, d); chk("R9 line high beats clear", d & 32'h2, 32'h2);
    src_line[33] = 1'b0;
    wr(12'h284, 32'h2);
    eoi(33);

    // R10 edge source 34
    wr(12'hC08, 32'h0000_0020, 4'b0001);
    rd(12'hC08, d); chk("R8 field 2", d, 32'h0000_0020);
    @(negedge clk); src_line[34] = 1'b1;
    rd(12'h204, d); chk("R10 rise", d & 32'h4, 32'h4);
    wr(12'h284, 32'h4);
    rd(12'h204, d); chk("R10 held high no repend", d & 32'h4, 0);
    @(negedge clk); src_line[34] = 1'b0;
    @(negedge clk); src_line[34] = 1'b1;
    @(negedge clk); src_line[34] = 1'b0;
    @(negedge clk);
    src_line[34] = 1'b1; cpu_ack = 1'b1; ack_id = 6'd34;
    @(negedge clk); cpu_ack = 1'b0;
    rd(12'h204, d); chk("R10 rise with ack stays pending", d & 32'h4, 32'h4);
    rd(12'h304, d); chk("R12 active 34", d & 32'h4, 32'h4);
    ack(34);
    rd(12'h204, d); chk("R10 ack clears edge", d & 32'h4, 0);
    src_line = '0;
    eoi(34);

    // random rounds, R11 with ties
    for (int it = 0; it < 40; it++) begin
      logic [31:0] w;
      wr(12'h180, 32'hFFFF_FFFF); wr(12'h184, 32'hFFFF_FFFF);
      wr(12'h280, 32'hFFFF_FFFF); wr(12'h284, 32'hFFFF_FFFF);
      wr(12'h380, 32'hFFFF_FFFF); wr(12'h384, 32'hFFFF_FFFF);
      for (int k = 0; k < 2; k++) begin
        w = $urandom; wr(12'h100 + 12'(k * 4), w); m_en[k*32 +: 32] = w;
        w = $urandom & $urandom; wr(12'h200 + 12'(k * 4), w); m_pd[k*32 +: 32] = w;
        w = $urandom & $urandom & $urandom; wr(12'h300 + 12'(k * 4), w); m_ac[k*32 +: 32] = w;
      end
      for (int k = 0; k < 16; k++) begin
        w = $urandom & 32'h0303_0303;
        wr(12'h400 + 12'(k * 4), w);
        for (int l = 0; l < 4; l++) m_pr[k*4 + l] = int'(w[l*8 +: 8]);
        w = $urandom;
        wr(12'h800 + 12'(k * 4), w);
        for (int l = 0; l < 4; l++) m_tg[k*4 + l] = w[l*8];
      end
      settle();
      check_pick("rand");
      if (cpu_irq) begin
        m_ac[cpu_id] = 1'b1;
        ack(int'(cpu_id));
        settle();
        check_pick("rand after R12 ack");
      end
    end

    summary();
    $finish;
  end
endmodule